// File: doc/BRIEF.md
# Segmented Kernel Address Translator

This block turns a 32-bit virtual address into a physical address through a fixed top-level split of the address space into sixteen 256 MB segments, chosen by the four most significant address bits. A software-loaded mode word marks each segment as either linear or paged. A linear segment is relocated by swapping its top nibble for a per-segment 4-bit base, so a whole 256 MB window maps onto physical memory with no table. A paged segment is passed out to an external page-translation port, and the block waits there for a physical page address or a fault.

A privilege input marks user-mode requests. User code may reach only segments 0 through A. A user request to segments B through F is refused with a fault, whatever that segment's mode. Requests are taken one at a time: `req_ready` is high only while the translator is idle. Every accepted request gives exactly one single-cycle response.

The controller has three states:
- `ST_IDLE`: waiting for a request. From here, an accepted linear or refused request goes to `ST_RESP`, and an accepted paged request goes to `ST_PAGE`.
- `ST_PAGE`: waiting for the page port. It leaves for `ST_RESP` when the page response arrives.
- `ST_RESP`: presents the result for one cycle, then always returns to `ST_IDLE`.

Top module: `kseg_translator`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `pg_req_valid` are 0. Every segment is linear with a base equal to its own index, so a kernel request returns its own address.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. For a permitted request to a linear segment, `rsp_valid` is 1 in the following cycle, with `rsp_addr = {base, va[27:0]}` and `rsp_fault = 0`.
- R3: The configuration port takes writes while `cfg_we` is 1, and `cfg_sel` picks the target. For `cfg_sel = 0`, bit i of `cfg_wdata[15:0]` sets segment i to paged (1) or linear (0). For `cfg_sel = 1`, nibble `cfg_wdata[4k+3:4k]` is the base of segment k, for k = 0 to 7. For `cfg_sel = 2`, that nibble is the base of segment k+8.
- R4: For a permitted request to a paged segment, `pg_req_valid` is 1 from the cycle after acceptance, with `pg_req_addr` equal to the virtual address. Both hold steady until `pg_rsp_valid` is seen.
- R5: `rsp_valid` rises in the cycle after `pg_rsp_valid` and carries `rsp_fault = pg_rsp_fault`. When there is no fault, `rsp_addr = {pg_rsp_addr[31:13], va[12:0]}`, so the 8 KB page offset is kept. When there is a fault, `rsp_addr = 0`.
- R6: A user request (`req_user = 1`) to segments B through F responds in the next cycle with `rsp_fault = 1` and `rsp_addr = 0`. No page request is made, even if the segment is paged.
- R7: A user request to segments 0 through A is translated exactly as a kernel request would be.
- R8: `req_ready` is 0 in `ST_PAGE` and `ST_RESP`. A `req_valid` raised in those states is ignored and produces no response.
- R9: A configuration write takes effect for the next accepted request. A write at the same edge that accepts a request does not change that request's translation.
- R10: `rsp_valid` is high for exactly one cycle per accepted request, and `req_ready` returns in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user-mode request |
| req_ready | output | 1 | Translator idle, request can be taken |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_addr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Translation refused |
| pg_req_valid | output | 1 | Page translation wanted |
| pg_req_addr | output | 32 | Virtual address sent to the page port |
| pg_rsp_valid | input | 1 | Page port answer |
| pg_rsp_addr | input | 32 | Physical page address from page port |
| pg_rsp_fault | input | 1 | Page port reports fault |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 mode word, 1 low bases, 2 high bases |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
The assertions check on every cycle the handshake properties:
- the ready/response/page-request exclusivity while busy;
- the single-cycle response pulse;
- a page request held stable until it is answered;
- the page-offset merge;
- the immediate fault on a user request to the upper segments.

The actual linear relocation values, the mode and base register field positions, and the rule that a write lands only on the next request can be shown only by the bench's scenarios. Those scenarios compare each response against a separately kept register model.

// File: rtl/kseg_pkg.sv
package kseg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RESP = 2'd1,
        ST_PAGE = 2'd2
    } kseg_state_e;

    typedef enum logic [1:0] {
        K_LINEAR = 2'd0,
        K_PAGED  = 2'd1,
        K_DENY   = 2'd2
    } kseg_kind_e;

    localparam logic [1:0] CFG_MODE    = 2'd0;
    localparam logic [1:0] CFG_BASE_LO = 2'd1;
    localparam logic [1:0] CFG_BASE_HI = 2'd2;
endpackage

// File: rtl/kseg_regs.sv
module kseg_regs
    import kseg_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [1:0]                  cfg_sel,
    input  logic [DATA_W-1:0]           cfg_wdata,
    output logic [(1<<SEG_W)-1:0]       seg_paged,
    output logic [(1<<SEG_W)*SEG_W-1:0] base_flat
);
    localparam int NSEG   = 1 << SEG_W;
    localparam int BASE_W = (NSEG / 2) * SEG_W;

    function automatic logic [NSEG*SEG_W-1:0] ident_bases();
        logic [NSEG*SEG_W-1:0] v;
        v = '0;
        for (int i = 0; i < NSEG; i++) begin
            v[i*SEG_W +: SEG_W] = SEG_W'(i);
        end
        return v;
    endfunction

    localparam logic [NSEG*SEG_W-1:0] RST_BASES = ident_bases();

    logic [NSEG-1:0]   mode_q;
    logic [BASE_W-1:0] base_lo_q;
    logic [BASE_W-1:0] base_hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            base_lo_q <= RST_BASES[BASE_W-1:0];
            base_hi_q <= RST_BASES[2*BASE_W-1:BASE_W];
        end else if (cfg_we) begin
            unique case (cfg_sel)
                CFG_MODE:    mode_q    <= cfg_wdata[NSEG-1:0];
                CFG_BASE_LO: base_lo_q <= cfg_wdata[BASE_W-1:0];
                CFG_BASE_HI: base_hi_q <= cfg_wdata[BASE_W-1:0];
                default: ;
            endcase
        end
    end

    assign seg_paged = mode_q;
    assign base_flat = {base_hi_q, base_lo_q};
endmodule

// File: rtl/kseg_lookup.sv
module kseg_lookup
    import kseg_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int SEG_W         = 4,
    parameter int USER_LAST_SEG = 10
) (
    input  logic [ADDR_W-1:0]           va,
    input  logic                        user,
    input  logic [(1<<SEG_W)-1:0]       seg_paged,
    input  logic [(1<<SEG_W)*SEG_W-1:0] base_flat,
    output kseg_kind_e                  kind,
    output logic [ADDR_W-1:0]           lin_pa
);
    logic [SEG_W-1:0] seg;
    logic [SEG_W-1:0] base;

    assign seg    = va[ADDR_W-1 -: SEG_W];
    assign base   = base_flat[int'(seg)*SEG_W +: SEG_W];
    assign lin_pa = {base, va[ADDR_W-SEG_W-1:0]};

    always_comb begin
        if (user && (seg > SEG_W'(USER_LAST_SEG))) begin
            kind = K_DENY;
        end else if (seg_paged[seg]) begin
            kind = K_PAGED;
        end else begin
            kind = K_LINEAR;
        end
    end
endmodule

// File: rtl/kseg_translator.sv
module kseg_translator
    import kseg_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int SEG_W         = 4,
    parameter int PAGE_BITS     = 13,
    parameter int USER_LAST_SEG = 10,
    parameter int DATA_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_user,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_fault,
    output logic              pg_req_valid,
    output logic [ADDR_W-1:0] pg_req_addr,
    input  logic              pg_rsp_valid,
    input  logic [ADDR_W-1:0] pg_rsp_addr,
    input  logic              pg_rsp_fault,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata
);
    localparam int NSEG = 1 << SEG_W;

    kseg_state_e              state_q, state_d;
    kseg_kind_e               kind;
    logic [NSEG-1:0]          seg_paged;
    logic [NSEG*SEG_W-1:0]    base_flat;
    logic [ADDR_W-1:0]        lin_pa;
    logic [ADDR_W-1:0]        va_q;
    logic [ADDR_W-1:0]        rsp_addr_q;
    logic                     rsp_fault_q;
    logic                     accept;
    logic                     pg_low_unused;

    kseg_regs #(.SEG_W(SEG_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .seg_paged (seg_paged),
        .base_flat (base_flat)
    );

    kseg_lookup #(
        .ADDR_W(ADDR_W), .SEG_W(SEG_W), .USER_LAST_SEG(USER_LAST_SEG)
    ) u_lookup (
        .va        (req_addr),
        .user      (req_user),
        .seg_paged (seg_paged),
        .base_flat (base_flat),
        .kind      (kind),
        .lin_pa    (lin_pa)
    );

    assign accept        = req_valid && (state_q == ST_IDLE);
    assign pg_low_unused = ^pg_rsp_addr[PAGE_BITS-1:0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = (kind == K_PAGED) ? ST_PAGE : ST_RESP;
            ST_PAGE: if (pg_rsp_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        req_ready    = 1'b0;
        rsp_valid    = 1'b0;
        pg_req_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready    = 1'b1;
            ST_RESP: rsp_valid    = 1'b1;
            ST_PAGE: pg_req_valid = 1'b1;
            default: ;
        endcase
    end

    // Request and result holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            rsp_addr_q  <= '0;
            rsp_fault_q <= 1'b0;
        end else if (accept) begin
            va_q        <= req_addr;
            rsp_addr_q  <= (kind == K_LINEAR) ? lin_pa : '0;
            rsp_fault_q <= (kind == K_DENY);
        end else if ((state_q == ST_PAGE) && pg_rsp_valid) begin
            rsp_addr_q  <= pg_rsp_fault ? '0
                         : {pg_rsp_addr[ADDR_W-1:PAGE_BITS], va_q[PAGE_BITS-1:0]};
            rsp_fault_q <= pg_rsp_fault;
        end
    end

    assign rsp_addr    = rsp_addr_q;
    assign rsp_fault   = rsp_fault_q;
    assign pg_req_addr = va_q;
endmodule

// File: rtl/kseg_translator_chk.sv
module kseg_translator_chk #(
    parameter int ADDR_W        = 32,
    parameter int SEG_W         = 4,
    parameter int PAGE_BITS     = 13,
    parameter int USER_LAST_SEG = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_user,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_fault,
    input logic              pg_req_valid,
    input logic [ADDR_W-1:0] pg_req_addr,
    input logic              pg_rsp_valid,
    input logic              pg_rsp_fault
);
    // R8: no readiness while a response or page request is outstanding
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !pg_req_valid));

    // R10: response is a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R4: page request holds until answered
    a_r4_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_req_valid && !pg_rsp_valid) |=> (pg_req_valid && $stable(pg_req_addr)));

    // R5: page offset comes from the virtual address
    a_r5_page_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_req_valid && pg_rsp_valid && !pg_rsp_fault) |=>
        (rsp_valid && !rsp_fault &&
         rsp_addr[PAGE_BITS-1:0] == $past(pg_req_addr[PAGE_BITS-1:0])));

    // R6: user access to upper segments faults at once
    a_r6_user_deny: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_user &&
         req_addr[ADDR_W-1 -: SEG_W] > SEG_W'(USER_LAST_SEG)) |=>
        (rsp_valid && rsp_fault && rsp_addr == '0));
endmodule

bind kseg_translator kseg_translator_chk #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .PAGE_BITS(PAGE_BITS), .USER_LAST_SEG(USER_LAST_SEG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_user     (req_user),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_addr     (rsp_addr),
    .rsp_fault    (rsp_fault),
    .pg_req_valid (pg_req_valid),
    .pg_req_addr  (pg_req_addr),
    .pg_rsp_valid (pg_rsp_valid),
    .pg_rsp_fault (pg_rsp_fault)
);

// File: tb/test_kseg_translator.sv
`timescale 1ns/1ps
module test_kseg_translator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_user = 1'b0;
    logic        req_ready, rsp_valid, rsp_fault, pg_req_valid;
    logic [31:0] rsp_addr, pg_req_addr;
    logic        pg_rsp_valid = 1'b0;
    logic [31:0] pg_rsp_addr = '0;
    logic        pg_rsp_fault = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    logic [15:0] m_mode;
    logic [31:0] m_lo, m_hi;

    always #2 clk = ~clk;

    kseg_translator i_kseg_translator (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_user(req_user),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .pg_req_valid(pg_req_valid), .pg_req_addr(pg_req_addr),
        .pg_rsp_valid(pg_rsp_valid), .pg_rsp_addr(pg_rsp_addr), .pg_rsp_fault(pg_rsp_fault),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // 0 linear, 1 deny, 2 paged
    function automatic int exp_kind(input logic [31:0] a, input logic u);
        if (u && a[31:28] > 4'hA) return 1;
        if (m_mode[a[31:28]]) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] exp_lin(input logic [31:0] a);
        logic [63:0] b;
        b = {m_hi, m_lo};
        return {b[a[31:28]*4 +: 4], a[27:0]};
    endfunction

    task automatic model_write(input logic [1:0] s, input logic [31:0] d);
        case (s)
            2'd0: m_mode = d[15:0];
            2'd1: m_lo = d;
            2'd2: m_hi = d;
            default: ;
        endcase
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(s, d);
    endtask

    task automatic do_req(input logic [31:0] a, input logic u, input string tag,
                          input bit wr, input logic [1:0] ws, input logic [31:0] wd,
                          input bit poke);
        int kind;
        int waits;
        logic [31:0] e_pa, pr, e_pg;
        bit pf;
        kind = exp_kind(a, u);
        e_pa = exp_lin(a);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_addr = a; req_user = u;
        if (wr) begin cfg_we = 1'b1; cfg_sel = ws; cfg_wdata = wd; end
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        if (wr) model_write(ws, wd);
        if (kind == 2) begin
            chk(pg_req_valid && !rsp_valid, "R4 page request raised", {31'd0, pg_req_valid}, 32'd1);
            chk(pg_req_addr == a, "R4 page request address", pg_req_addr, a);
            waits = poke ? 1 + int'($urandom % 3) : int'($urandom % 4);
            for (int w = 0; w < waits; w++) begin
                if (poke && w == 0) begin req_valid = 1'b1; req_addr = ~a; req_user = 1'b1; end
                @(negedge clk);
                req_valid = 1'b0;
                chk(pg_req_valid && pg_req_addr == a, "R4 page request held", pg_req_addr, a);
                chk(!req_ready && !rsp_valid, "R8 busy while paging", {31'd0, req_ready}, 32'd0);
            end
            pr = $urandom;
            pf = ($urandom % 5) == 0;
            pg_rsp_valid = 1'b1; pg_rsp_addr = pr; pg_rsp_fault = pf;
            @(negedge clk);
            pg_rsp_valid = 1'b0;
            e_pg = pf ? 32'd0 : {pr[31:13], a[12:0]};
            chk(rsp_valid == 1'b1, "R5 response after page answer", {31'd0, rsp_valid}, 32'd1);
            chk(rsp_addr == e_pg, "R5 paged address", rsp_addr, e_pg);
            chk(rsp_fault == pf, "R5 paged fault", {31'd0, rsp_fault}, {31'd0, pf});
        end else if (kind == 1) begin
            chk(rsp_valid && !pg_req_valid, "R6 deny response", {31'd0, rsp_valid}, 32'd1);
            chk(rsp_fault == 1'b1 && rsp_addr == 32'd0, "R6 deny fault", rsp_addr, 32'd0);
        end else begin
            chk(rsp_valid && !pg_req_valid, {tag, " linear response"}, {31'd0, rsp_valid}, 32'd1);
            chk(rsp_addr == e_pa && !rsp_fault, {tag, " linear address"}, rsp_addr, e_pa);
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R10 single response pulse", {31'd0, rsp_valid}, 32'd0);
        if (poke) begin
            @(negedge clk);
            chk(!rsp_valid, "R8 ignored request gave no response", {31'd0, rsp_valid}, 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'h5EC7_0A11));
        m_mode = 16'h0000; m_lo = 32'h7654_3210; m_hi = 32'hFEDC_BA98;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_valid && !pg_req_valid, "R1 reset outputs", {29'd0, req_ready, rsp_valid, pg_req_valid}, 32'h4);
        for (int s = 0; s < 16; s++) begin
            do_req({s[3:0], 28'h123_4567} ^ 32'(s), 1'b0, "R1", 1'b0, 2'd0, '0, 1'b0);
        end

        // R3 layout: seg F=0,E=8,D=x,C=4,B=B; D and 0..A paged
        cfg_write(2'd2, 32'h0804_B000);
        cfg_write(2'd0, 32'h0000_27FF);
        do_req(32'hC000_0000, 1'b0, "R3", 1'b0, 2'd0, '0, 1'b0);
        do_req(32'hCFFF_FFFF, 1'b0, "R2", 1'b0, 2'd0, '0, 1'b0);
        do_req(32'hE000_1234, 1'b0, "R3", 1'b0, 2'd0, '0, 1'b0);
        do_req(32'hF000_1234, 1'b0, "R2", 1'b0, 2'd0, '0, 1'b0);
        do_req(32'hB000_0010, 1'b0, "R2", 1'b0, 2'd0, '0, 1'b0);
        do_req(32'hD004_000C, 1'b0, "R4", 1'b0, 2'd0, '0, 1'b0);
        do_req(32'h0000_1FFF, 1'b0, "R5", 1'b0, 2'd0, '0, 1'b0);

        // R6 user denied in upper segments, paged or linear; R7 lower ones pass
        do_req(32'hB000_0000, 1'b1, "R6", 1'b0, 2'd0, '0, 1'b0);
        do_req(32'hD000_0000, 1'b1, "R6", 1'b0, 2'd0, '0, 1'b0);
        do_req(32'hFFFF_FFFF, 1'b1, "R6", 1'b0, 2'd0, '0, 1'b0);
        do_req(32'hAFFF_FFFF, 1'b1, "R7", 1'b0, 2'd0, '0, 1'b0);
        cfg_write(2'd0, 32'h0000_0000);
        do_req(32'hAFFF_FFFF, 1'b1, "R7", 1'b0, 2'd0, '0, 1'b0);

        // R9 write at accept edge is not seen; next request sees it
        do_req(32'hC000_0040, 1'b0, "R9", 1'b1, 2'd0, 32'h0000_1000, 1'b0);
        do_req(32'hC000_0040, 1'b0, "R9", 1'b0, 2'd0, '0, 1'b0);
        do_req(32'h1000_0000, 1'b0, "R9", 1'b1, 2'd1, 32'h0000_00A0, 1'b0);
        do_req(32'h1000_0000, 1'b0, "R9", 1'b0, 2'd0, '0, 1'b0);

        // R8 request during page wait is ignored
        do_req(32'hC123_4567, 1'b0, "R8", 1'b0, 2'd0, '0, 1'b1);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 8) == 0) cfg_write(2'($urandom % 3), $urandom);
            do_req($urandom, 1'($urandom), "R2", (($urandom % 10) == 0), 2'($urandom % 3), $urandom,
                   (($urandom % 16) == 0));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule